// File: doc/BRIEF.md
# Self-Refresh Entry and Exit Sequencer

This block sits in a DRAM controller and moves the attached device into self-refresh and back out. When the host asks to enter and reports that every bank is idle, the sequencer drives a one-cycle refresh command with the clock enable low. It then keeps the clock enable low, so the device holds its data without external clocking. While the device is in that state, all other command lines are irrelevant, and the sequencer drives a NOP on them.

When the host asks to leave, the sequencer waits for the clock-stable indication before it raises the clock enable. It also pulses a DLL/termination reset toward the PHY. It then holds the command bus at NOP for a recovery window of `T_XSNR` cycles. After that window, ordinary commands may resume. Reads stay blocked until `T_RDLOCK` cycles after the clock enable rose, which gives the DLL time to relock and the drivers time to recalibrate. The host uses `ready_cmd` and `ready_read` to gate its own traffic. The sequencer drives the command bus only while it is in charge of it: the refresh-entry cycle and the NOP periods.

Top module: `sr_seq`

## Requirements
- R1: After reset, `cke` is 1, `cmd` is NOP (3'b111), `ready_cmd` and `ready_read` are 1, and `dll_rst` is 0.
- R2: An `enter_req` sampled high while idle with `banks_idle` high drives `cmd` to REFRESH (3'b001, encoding {ras_n,cas_n,we_n}) with `cke` 0 for exactly one cycle starting after that edge. In the following cycles `cmd` is NOP with `cke` still 0.
- R3: An `enter_req` sampled while `banks_idle` is 0 has no effect; all outputs keep their idle values.
- R4: Once in self-refresh, `cke` stays 0 and `cmd` stays NOP regardless of `enter_req` or `clk_stable`, until `exit_req` is sampled high.
- R5: `exit_req` is ignored outside self-refresh, both when idle and during exit recovery.
- R6: After `exit_req`, `cke` stays 0 for as long as `clk_stable` is 0. `cke` rises in the cycle after the first edge that samples `clk_stable` high.
- R7: During the `T_XSNR` cycles that begin with the cycle in which `cke` rises, `cmd` is NOP and `ready_cmd` is 0. `ready_cmd` rises exactly `T_XSNR` cycles after `cke` rises.
- R8: `ready_read` rises exactly `T_RDLOCK` cycles after `cke` rises, and `ready_cmd` stays 1 from its rise onward. An `enter_req` sampled before `ready_read` rises is ignored.
- R9: `dll_rst` is 1 for exactly one cycle, the cycle in which `cke` rises, and is 0 at all other times.
- R10: `ready_read` high implies `ready_cmd` high, and `cke` low implies both ready outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Host request to enter self-refresh |
| exit_req | input | 1 | Host request to leave self-refresh |
| banks_idle | input | 1 | Host indication that all banks are precharged |
| clk_stable | input | 1 | Device clock is stable |
| cke | output | 1 | Clock enable to the device |
| cmd | output | 3 | Command {ras_n,cas_n,we_n}; 111 NOP, 001 REFRESH |
| ready_cmd | output | 1 | Non-read commands may be issued |
| ready_read | output | 1 | Reads may be issued |
| dll_rst | output | 1 | One-cycle DLL/termination reset pulse on exit |

## Verification
Every result appears one cycle after the edge that samples its cause. The refresh command follows the edge that accepts `enter_req`. The rise of `cke` follows the edge that sees `clk_stable`. `ready_cmd` and `ready_read` rise `T_XSNR` and `T_RDLOCK` cycles after the `cke` rise cycle. The bench drives inputs and reads outputs 1 ns after each rising edge, so each read shows the state that the edge just loaded. The bench counts cycles from the `cke` rise and compares both ready outputs against that cycle index in every cycle of the recovery window. It repeats the sequence for several `clk_stable` delays.

// File: rtl/sr_seq.sv
module sr_seq #(
  parameter int T_XSNR   = 200,
  parameter int T_RDLOCK = 20000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req,
  input  logic       exit_req,
  input  logic       banks_idle,
  input  logic       clk_stable,
  output logic       cke,
  output logic [2:0] cmd,
  output logic       ready_cmd,
  output logic       ready_read,
  output logic       dll_rst
);
  localparam int CW = $clog2(T_RDLOCK + 1);
  localparam logic [2:0] C_NOP = 3'b111;
  localparam logic [2:0] C_REF = 3'b001;

  typedef enum logic [2:0] {S_IDLE, S_ENTER, S_SELF, S_WAITCLK, S_XSNR, S_DLLWAIT} state_t;

  state_t        state, nxt;
  logic [CW-1:0] cnt;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:    if (enter_req && banks_idle) nxt = S_ENTER;
      S_ENTER:   nxt = S_SELF;
      S_SELF:    if (exit_req) nxt = S_WAITCLK;
      S_WAITCLK: if (clk_stable) nxt = S_XSNR;
      S_XSNR:    if (cnt == CW'(T_XSNR - 1)) nxt = S_DLLWAIT;
      S_DLLWAIT: if (cnt == CW'(T_RDLOCK - 1)) nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if ((state == S_XSNR || state == S_DLLWAIT) && nxt != S_IDLE) cnt <= cnt + 1'b1;
      else cnt <= '0;
    end
  end

  assign cke        = !(state inside {S_ENTER, S_SELF, S_WAITCLK});
  assign cmd        = (state == S_ENTER) ? C_REF : C_NOP;
  assign ready_cmd  = (state == S_IDLE) || (state == S_DLLWAIT);
  assign ready_read = (state == S_IDLE);
  assign dll_rst    = (state == S_XSNR) && (cnt == '0);
endmodule

// File: rtl/sr_seq_chk.sv
module sr_seq_chk #(
  parameter int T_XSNR   = 200,
  parameter int T_RDLOCK = 20000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_stable,
  input logic       cke,
  input logic [2:0] cmd,
  input logic       ready_cmd,
  input logic       ready_read,
  input logic       dll_rst
);
  localparam int SW = $clog2(T_RDLOCK + 2);
  logic          cke_q;
  logic [SW-1:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q <= 1'b1;
      since <= '0;
    end else begin
      cke_q <= cke;
      if (!cke) since <= '0;
      else if (!cke_q) since <= SW'(1);
      else if (since != '0 && since != SW'(T_RDLOCK + 1)) since <= since + 1'b1;
    end
  end

  a_r2_ref_with_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'b001 |-> !cke);
  a_r2_ref_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 3'b001 |=> cmd == 3'b111);
  a_r6_cke_after_stable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(clk_stable));
  a_r7_nop_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !ready_cmd) |-> cmd == 3'b111);
  a_r7_cmd_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_cmd) |-> since == SW'(T_XSNR));
  a_r8_read_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_read) |-> since == SW'(T_RDLOCK));
  a_r9_rst_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> dll_rst);
  a_r9_rst_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    dll_rst |-> $rose(cke));
  a_r10_read_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ready_read |-> ready_cmd);
  a_r10_blocked_when_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!ready_cmd && !ready_read));
endmodule

bind sr_seq sr_seq_chk #(.T_XSNR(T_XSNR), .T_RDLOCK(T_RDLOCK)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable), .cke(cke), .cmd(cmd),
  .ready_cmd(ready_cmd), .ready_read(ready_read), .dll_rst(dll_rst)
);

// File: tb/sim_sr_seq.sv
`timescale 1ns/1ps
module sim_sr_seq;
  localparam int TX = 5;
  localparam int TR = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enter_req = 0, exit_req = 0, banks_idle = 0, clk_stable = 0;
  logic cke, ready_cmd, ready_read, dll_rst;
  logic [2:0] cmd;
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sr_seq #(.T_XSNR(TX), .T_RDLOCK(TR)) u0 (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
    .banks_idle(banks_idle), .clk_stable(clk_stable), .cke(cke), .cmd(cmd),
    .ready_cmd(ready_cmd), .ready_read(ready_read), .dll_rst(dll_rst));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle_outputs(input string req);
    check({req, " cke"}, cke, 1);
    check({req, " cmd"}, cmd, 7);
    check({req, " ready_cmd"}, ready_cmd, 1);
    check({req, " ready_read"}, ready_read, 1);
    check({req, " dll_rst"}, dll_rst, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    idle_outputs("R1 reset");
    for (int d = 0; d < 4; d++) begin
      exit_req = 1; step(); exit_req = 0;
      idle_outputs("R5 exit while idle");
      enter_req = 1; banks_idle = 0; step(); enter_req = 0;
      idle_outputs("R3 banks busy");
      enter_req = 1; banks_idle = 1; step(); enter_req = 0;
      check("R2 cke low on entry", cke, 0);
      check("R2 refresh cmd", cmd, 1);
      check("R10 ready_cmd low", ready_cmd, 0);
      check("R10 ready_read low", ready_read, 0);
      step();
      check("R2 nop after refresh", cmd, 7);
      check("R2 cke held low", cke, 0);
      for (int k = 0; k < 4; k++) begin
        enter_req = k[0]; clk_stable = k[1]; step();
        check("R4 self cke", cke, 0);
        check("R4 self cmd", cmd, 7);
      end
      enter_req = 0; clk_stable = 0;
      exit_req = 1; step(); exit_req = 0;
      check("R6 cke low before stable", cke, 0);
      for (int k = 0; k < d; k++) begin
        step();
        check("R6 cke waits for clock", cke, 0);
      end
      clk_stable = 1; step();
      for (int i = 0; i <= TR; i++) begin
        check("R6 cke high", cke, 1);
        check("R7 cmd nop", cmd, 7);
        check("R7 ready_cmd timing", ready_cmd, (i >= TX) ? 1 : 0);
        check("R8 ready_read timing", ready_read, (i >= TR) ? 1 : 0);
        check("R9 dll_rst pulse", dll_rst, (i == 0) ? 1 : 0);
        if (i < TR) begin
          exit_req   = (i == 2);
          enter_req  = (i == TX + 1);
          banks_idle = 1;
          step();
          exit_req = 0; enter_req = 0;
        end
      end
      clk_stable = 0;
      step();
      idle_outputs("R5 R8 back to idle");
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule